// File: doc/BRIEF.md
# In-Place CORDIC FFT/IFFT Engine

This block computes a fixed-point, radix-2, decimation-in-frequency discrete Fourier transform, forward or inverse, over a small power-of-two frame (16 complex points by default). One working memory holds the frame for the whole job. Samples are written into it through a simple load port while the engine is idle. A start pulse then runs every butterfly of every stage through a single shared butterfly unit. Each butterfly reads two locations and writes both results back to those same two locations.

Inside the butterfly, the half-sum goes straight back to memory. The half-difference is turned by the twiddle angle in an iterative shift-and-add rotator instead of a complex multiplier. The rotator first removes its fixed gain with one constant scale. It then folds the angle by a quarter turn when the angle lies outside its convergence range. After the last stage the bins sit at bit-reversed addresses. The unload phase therefore reads the same memory through a bit-reversed address, so the bins leave in natural order without a second buffer.

A single mode input, captured at start, picks the forward transform or the conjugate-twiddle inverse. Every stage halves its outputs, so either direction carries an overall scale of 1/N and cannot overflow inside the memory.

Top module: `cordic_fft`

## Requirements
- R1: While reset is held and after it is released, busy, done and out_valid are low.
- R2: While busy is low, each cycle with in_valid high writes (in_re, in_im) to the next sample position. The first sample after reset or after an accepted start goes to position 0. in_valid is ignored while busy is high.
- R3: With inverse low at start, output bin k equals (1/N)·Σn x[n]·e^(−j2πkn/N) within ±6 LSB on each component.
- R4: With inverse high at start, output bin k equals (1/N)·Σn x[n]·e^(+j2πkn/N) within ±6 LSB on each component. A tone at bin b of the forward transform therefore shows up at bin N−b.
- R5: A start pulse while busy is high is ignored, and the running transform's results are unchanged.
- R6: During unload, out_valid is high for exactly N consecutive cycles, and out_idx counts 0, 1, …, N−1 with the matching bin on out_re/out_im.
- R7: busy rises in the cycle after an accepted start and stays high until done. done is high for exactly one cycle, the cycle after the last bin. busy falls the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample write strobe (idle only) |
| in_re | input | W | Sample real part, two's complement |
| in_im | input | W | Sample imaginary part, two's complement |
| start | input | 1 | Begin a transform when idle |
| inverse | input | 1 | 0 = forward, 1 = inverse; captured at start |
| busy | output | 1 | Transform or unload in progress |
| done | output | 1 | One-cycle end marker after the last bin |
| out_valid | output | 1 | Bin present on out_re/out_im |
| out_idx | output | log2(N) | Natural-order bin number |
| out_re | output | W | Bin real part |
| out_im | output | W | Bin imaginary part |

## Verification
An impulse checks that every bin gets the same value. An engine that loses the 1/N scale, or that writes a result to the wrong half of a butterfly pair, breaks that flat spectrum at once. A complex tone run through both modes exposes a sign error in the rotation direction: the energy would land on bin 3 in the inverse run instead of bin 13, or the reverse. A broken bit-reversed unload would scatter the tone to the wrong out_idx. Mixed pseudo-random frames catch wrong pair spacing, a twiddle index that steps wrongly in later stages, and quarter-turn folding errors for angles past 90 degrees. A start and load strobe injected mid-run shows whether the engine restarts or lets the load port corrupt its working memory.

// File: rtl/cordic_fft.sv
module cordic_fft #(
  parameter int N = 16,
  parameter int W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [W-1:0]     in_re,
  input  logic signed [W-1:0]     in_im,
  input  logic                    start,
  input  logic                    inverse,
  output logic                    busy,
  output logic                    done,
  output logic                    out_valid,
  output logic [$clog2(N)-1:0]    out_idx,
  output logic signed [W-1:0]     out_re,
  output logic signed [W-1:0]     out_im
);
  localparam int M  = $clog2(N);
  localparam int CW = W + 3;
  localparam int IW = $clog2(W);
  localparam int PW = 2 * W + 2;
  localparam logic signed [W+1:0] KC  = (W+2)'(64'd2608131496 >> (33 - W));
  localparam logic signed [31:0]  QTR = 32'sh4000_0000;

  typedef enum logic [2:0] {S_IDLE, S_BFLY, S_ROT, S_WB, S_OUT, S_DONE} st_t;
  st_t st;

  logic signed [W-1:0] mre [N];
  logic signed [W-1:0] mim [N];
  logic [M-1:0]  lptr, uptr, ur, span, ia, ib, tw, jm;
  logic [M-2:0]  j;
  logic [M-1:0]  stg;
  logic [IW-1:0] it;
  logic          inv_q;
  logic signed [CW-1:0] x, y, xs, ys, x0, y0;
  logic signed [31:0]   z, za, z0;
  logic signed [W:0]    sre, sim, dre, dim;

  function automatic logic signed [CW-1:0] gain_fix(input logic signed [W-1:0] d);
    logic signed [PW-1:0] p;
    p = (PW'(d) * PW'(KC)) >>> (W - 3);
    return p[CW-1:0];
  endfunction

  function automatic logic signed [W-1:0] sat(input logic signed [CW-1:0] v);
    logic signed [CW-1:0] r;
    r = CW'((v + 2) >>> 2);
    if (r[CW-1:W-1] != {(CW-W+1){r[CW-1]}})
      return r[CW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    return r[W-1:0];
  endfunction

  function automatic logic signed [31:0] atan_f(input logic [IW-1:0] i);
    case (i)
      0:  return 32'sd536870912;
      1:  return 32'sd316933406;
      2:  return 32'sd167458907;
      3:  return 32'sd85004756;
      4:  return 32'sd42667331;
      5:  return 32'sd21354465;
      6:  return 32'sd10679838;
      7:  return 32'sd5340245;
      8:  return 32'sd2670163;
      9:  return 32'sd1335087;
      10: return 32'sd667544;
      11: return 32'sd333772;
      12: return 32'sd166886;
      13: return 32'sd83443;
      14: return 32'sd41722;
      15: return 32'sd20861;
      default: return 32'(32'sd683565276 >>> i);
    endcase
  endfunction

  assign jm   = {1'b0, j};
  assign span = M'(1) << (M - 1 - stg);
  assign ia   = ((jm >> (M - 1 - stg)) << (M - stg)) | (jm & (span - M'(1)));
  assign ib   = ia | span;
  assign tw   = (jm & (span - M'(1))) << stg;

  assign sre = mre[ia] + mre[ib];
  assign sim = mim[ia] + mim[ib];
  assign dre = mre[ia] - mre[ib];
  assign dim = mim[ia] - mim[ib];
  assign xs  = gain_fix(dre[W:1]);
  assign ys  = gain_fix(dim[W:1]);

  always_comb begin
    za = {tw, {(32-M){1'b0}}};
    if (!inv_q) za = -za;
    x0 = xs; y0 = ys; z0 = za;
    if (za > QTR) begin
      x0 = -ys; y0 = xs; z0 = za - QTR;
    end else if (za < -QTR) begin
      x0 = ys; y0 = -xs; z0 = za + QTR;
    end
  end

  always_comb
    for (int i = 0; i < M; i++) ur[i] = uptr[M-1-i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; lptr <= '0; uptr <= '0; j <= '0; stg <= '0; it <= '0;
      inv_q <= 1'b0; x <= '0; y <= '0; z <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (in_valid) lptr <= lptr + M'(1);
          if (start) begin
            st <= S_BFLY; inv_q <= inverse; lptr <= '0; stg <= '0; j <= '0;
          end
        end
        S_BFLY: begin
          x <= x0; y <= y0; z <= z0; it <= '0; st <= S_ROT;
        end
        S_ROT: begin
          if (!z[31]) begin
            x <= x - (y >>> it); y <= y + (x >>> it); z <= z - atan_f(it);
          end else begin
            x <= x + (y >>> it); y <= y - (x >>> it); z <= z + atan_f(it);
          end
          if (it == IW'(W - 1)) st <= S_WB;
          else it <= it + IW'(1);
        end
        S_WB: begin
          if (j == '1) begin
            j <= '0;
            if (stg == M'(M - 1)) begin st <= S_OUT; uptr <= '0; end
            else begin stg <= stg + M'(1); st <= S_BFLY; end
          end else begin
            j <= j + 1'b1; st <= S_BFLY;
          end
        end
        S_OUT: begin
          uptr <= uptr + M'(1);
          if (uptr == M'(N - 1)) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_IDLE && in_valid) begin
      mre[lptr] <= in_re; mim[lptr] <= in_im;
    end else if (st == S_BFLY) begin
      mre[ia] <= sre[W:1]; mim[ia] <= sim[W:1];
    end else if (st == S_WB) begin
      mre[ib] <= sat(x); mim[ib] <= sat(y);
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign out_valid = (st == S_OUT);
  assign out_idx   = uptr;
  assign out_re    = mre[ur];
  assign out_im    = mim[ur];
endmodule

// File: rtl/cordic_fft_chk.sv
module cordic_fft_chk #(
  parameter int N = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 out_valid,
  input logic [$clog2(N)-1:0] out_idx
);
  localparam int M = $clog2(N);

  // R7
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R6
  unload_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (busy && !done));
  // R6
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_idx != M'(N - 1)) |=> (out_valid && out_idx == $past(out_idx) + M'(1)));
  // R6
  last_bin_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_idx == M'(N - 1)) |=> (done && !out_valid));
endmodule

bind cordic_fft cordic_fft_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .out_valid(out_valid), .out_idx(out_idx)
);

// File: tb/tb_cordic_fft.sv
module tb_cordic_fft;
  localparam int N = 16;
  localparam int W = 16;
  localparam int M = $clog2(N);
  localparam real TOL = 6.0;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, start = 1'b0, inverse = 1'b0;
  logic signed [W-1:0] in_re = '0, in_im = '0;
  logic busy, done, out_valid;
  logic [M-1:0] out_idx;
  logic signed [W-1:0] out_re, out_im;

  int checks = 0, fails = 0;
  int vre [N];
  int vim [N];
  int gre [N];
  int gim [N];

  always #10 clk = ~clk;

  cordic_fft #(.N(N), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .start(start), .inverse(inverse), .busy(busy), .done(done),
    .out_valid(out_valid), .out_idx(out_idx), .out_re(out_re), .out_im(out_im)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load_frame();
    for (int n = 0; n < N; n++) begin
      @(negedge clk);
      in_valid = 1'b1; in_re = W'(vre[n]); in_im = W'(vim[n]);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run(input bit inv, input bit inject);
    int cnt, cyc;
    bit seq_ok;
    @(negedge clk);
    start = 1'b1; inverse = inv;
    @(negedge clk);
    start = 1'b0; inverse = 1'b0;
    chk(busy == 1'b1, "R7 busy after start", int'(busy), 1);
    if (inject) begin
      repeat (40) @(negedge clk);
      start = 1'b1; inverse = ~inv; in_valid = 1'b1; in_re = 16'sh1234; in_im = -16'sh0777;
      @(negedge clk);
      start = 1'b0; inverse = 1'b0; in_valid = 1'b0;
    end
    cnt = 0; cyc = 0; seq_ok = 1'b1;
    while (cnt < N && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (!busy || done) seq_ok = 1'b0;
      if (out_valid) begin
        if (int'(out_idx) != cnt) seq_ok = 1'b0;
        gre[out_idx] = int'(out_re);
        gim[out_idx] = int'(out_im);
        cnt++;
      end else if (cnt != 0) seq_ok = 1'b0;
    end
    chk(cnt == N, "R6 bin count", cnt, N);
    chk(seq_ok, "R6 natural order, busy held", int'(seq_ok), 1);
    @(negedge clk);
    chk(done && busy && !out_valid, "R7 done after last bin", int'(done), 1);
    @(negedge clk);
    chk(!done && !busy, "R7 done one cycle then idle", int'(busy), 0);
  endtask

  task automatic compare(input bit inv, input string tag);
    int bad = 0, worst_a = 0, worst_e = 0;
    for (int k = 0; k < N; k++) begin
      real er = 0.0, ei = 0.0, ph;
      for (int n = 0; n < N; n++) begin
        ph = 2.0 * PI * real'(k * n) / real'(N);
        if (inv) ph = -ph;
        er += real'(vre[n]) * $cos(ph) + real'(vim[n]) * $sin(ph);
        ei += real'(vim[n]) * $cos(ph) - real'(vre[n]) * $sin(ph);
      end
      er /= real'(N); ei /= real'(N);
      if ((real'(gre[k]) - er > TOL) || (er - real'(gre[k]) > TOL) ||
          (real'(gim[k]) - ei > TOL) || (ei - real'(gim[k]) > TOL)) begin
        if (bad == 0) begin worst_a = gre[k]; worst_e = int'(er); end
        bad++;
      end
    end
    chk(bad == 0, tag, worst_a, worst_e);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !out_valid, "R1 during reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !out_valid, "R1 after reset", int'(out_valid), 0);
  endtask

  task automatic t_impulse();
    for (int n = 0; n < N; n++) begin vre[n] = 0; vim[n] = 0; end
    vre[0] = 8000;
    load_frame();
    run(1'b0, 1'b0);
    compare(1'b0, "R3 impulse flat spectrum");
    chk(gre[N-1] >= 494 && gre[N-1] <= 506, "R3 impulse last bin", gre[N-1], 500);
  endtask

  task automatic t_tone();
    for (int n = 0; n < N; n++) begin
      vre[n] = $rtoi(4000.0 * $cos(2.0 * PI * 3.0 * real'(n) / real'(N)));
      vim[n] = $rtoi(4000.0 * $sin(2.0 * PI * 3.0 * real'(n) / real'(N)));
    end
    load_frame();
    run(1'b0, 1'b0);
    compare(1'b0, "R3 tone forward");
    chk(gre[3] > 3990 && gre[3] < 4010, "R3 tone at bin 3", gre[3], 4000);
    load_frame();
    run(1'b1, 1'b0);
    compare(1'b1, "R4 tone inverse");
    chk(gre[13] > 3990 && gre[13] < 4010, "R4 tone mirrored to bin 13", gre[13], 4000);
  endtask

  task automatic t_mixed(input int seed0);
    int s = seed0;
    for (int n = 0; n < N; n++) begin
      s = s * 1103515245 + 12345; vre[n] = ((s >>> 16) & 16'h3fff) - 8192;
      s = s * 1103515245 + 12345; vim[n] = ((s >>> 16) & 16'h3fff) - 8192;
    end
    load_frame();
    run(1'b0, 1'b0);
    compare(1'b0, "R3 mixed frame forward");
    load_frame();
    run(1'b1, 1'b0);
    compare(1'b1, "R4 mixed frame inverse");
  endtask

  task automatic t_ignore();
    for (int n = 0; n < N; n++) begin
      vre[n] = (n * 731) % 9000 - 4500; vim[n] = 3000 - (n * 377) % 6000;
    end
    load_frame();
    run(1'b0, 1'b1);
    compare(1'b0, "R5 R2 start and load ignored while busy");
    load_frame();
    run(1'b0, 1'b0);
    compare(1'b0, "R2 load pointer restarts at 0");
  endtask

  initial begin
    t_reset();
    t_impulse();
    t_tone();
    t_mixed(7);
    t_mixed(99);
    t_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule